// File: doc/BRIEF.md
# CAN Status and Fault-Confinement Register

This block is the read-only 32-bit status word of a CAN controller. It collects three kinds of information. The first is the live activity of the protocol engine: transmitting, transmitting an overload frame, receiving. The second is single-cycle error, timestamp and timer-wrap pulses. The third is the current transmit and receive error counters. From the counters it works out the fault-confinement state: warning, error-passive, bus-off and error-active. Live levels are passed straight through. Events and confinement states are held in sticky flags that clear when the register is read.

A read is requested by holding `rd_en_i` high for one cycle. The word appears on `rd_data_o`, qualified by `rd_valid_o`, on the following cycle. The read port has no back-pressure: every request is accepted, there is no ready signal, and the requester must take the word in the cycle it is valid. A read returns the flags as they stood before the clear. An event that arrives in the same cycle as the read is kept for the next read.

The sixteen mailbox event bits are live. Each one is the OR of that mailbox's ready and abort indications.

Top module: `can_status_reg`

## Requirements
- R1: While `rst_n` is low, `rd_valid_o` is 0 and `rd_data_o` is all zeros. Every sticky flag resets to 0.
- R2: A cycle with `rd_en_i` high makes `rd_valid_o` high for exactly the next cycle, with the word on `rd_data_o`. A cycle without `rd_en_i` leaves `rd_valid_o` low on the next cycle.
- R3: Bits 31, 30 and 29 return the live overload-transmit, transmit-busy and receive-busy inputs as sampled in the read cycle. Reads do not change them.
- R4: An error pulse sets a sticky flag, which stays set until a read: bit error sets bit 28, form error bit 27, acknowledge error bit 26, stuff error bit 25, CRC error bit 24.
- R5: A read returns the sticky flags held before that read, then clears every flag whose condition is not active in the read cycle.
- R6: An event or condition active in the same cycle as a read is absent from that read's word and present in the next read.
- R7: A timestamp pulse sets sticky bit 23. A timer-wrap pulse (the 16-bit timer rolling from 0xFFFF to 0x0000) sets sticky bit 22.
- R8: Bit 20 (sleep) equals the live low-power input and bit 21 (wakeup) is its complement, so the two bits always differ.
- R9: Sticky bit 19 (bus-off) is set in every cycle where the transmit error counter is 256 or more.
- R10: Sticky bit 18 (error-passive) is set in every cycle where either counter is 128 or more. A transmit count of 127 alone does not set it.
- R11: Sticky bit 17 (warning) is set in every cycle where either counter is 96 or more.
- R12: Sticky bit 16 (error-active) is set in every cycle where the node is neither error-passive nor bus-off. It therefore sets just after reset, while both counters are 0.
- R13: Bit n (n = 0 to 15) is the live OR of mailbox n's ready and abort inputs in the read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en_i | input | 1 | Read request, one cycle per read |
| tx_busy_i | input | 1 | Transmitter generating a frame |
| tx_ovl_i | input | 1 | Transmitter sending an overload frame |
| rx_busy_i | input | 1 | Receiver acquiring a frame |
| err_bit_i | input | 1 | Bit error pulse |
| err_form_i | input | 1 | Form error pulse |
| err_ack_i | input | 1 | Acknowledge error pulse |
| err_stuff_i | input | 1 | Stuff error pulse |
| err_crc_i | input | 1 | CRC error pulse |
| tstamp_i | input | 1 | Start or end of frame timestamp pulse |
| tmr_wrap_i | input | 1 | Timer wrap pulse |
| low_power_i | input | 1 | Controller in low-power mode |
| tec_i | input | 9 | Transmit error counter |
| rec_i | input | 8 | Receive error counter |
| mbx_rdy_i | input | 16 | Per-mailbox ready indications |
| mbx_abt_i | input | 16 | Per-mailbox abort indications |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Status word |

## Verification
The assertions check the following on every cycle:
- Each sticky flag sets after its event and drops after a read when its condition is absent.
- The bus-off state implies error-passive, and error-passive implies warning.
- `rd_valid_o` follows a request by exactly one cycle.
- Every returned word has sleep and wakeup complementary and carries the transmit-busy level of the read cycle.

Some behaviour needs whole sequences, so only the bench scenarios show it:
- The exact confinement thresholds, including 127 against 128.
- The pre-clear read value.
- An event coinciding with a read being kept for the next read.
- Level conditions re-setting their flags after a read.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;
  localparam int STAT_W   = 32;
  localparam int STICKY_N = 11;
  // sticky vector: [10:6] bit,form,ack,stuff,crc  [5] tstamp [4] wrap
  //                [3] bus-off [2] passive [1] warning [0] active
  localparam int S_TSTP = 5;
  localparam int S_WRAP = 4;
  localparam int S_BOFF = 3;
  localparam int S_PASS = 2;
  localparam int S_WARN = 1;
  localparam int S_ACT  = 0;

  typedef struct packed {
    logic boff;
    logic pass;
    logic warn;
    logic act;
  } conf_t;
endpackage

// File: rtl/can_conf_state.sv
module can_conf_state
  import can_stat_pkg::*;
#(
  parameter int TEC_W    = 9,
  parameter int REC_W    = 8,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128,
  parameter int BOFF_LIM = 256
) (
  input  logic [TEC_W-1:0] tec_i,
  input  logic [REC_W-1:0] rec_i,
  output conf_t            conf_o
);
  localparam logic [TEC_W-1:0] TEC_WARN = TEC_W'(WARN_LIM);
  localparam logic [TEC_W-1:0] TEC_PASS = TEC_W'(PASS_LIM);
  localparam logic [TEC_W-1:0] TEC_BOFF = TEC_W'(BOFF_LIM);
  localparam logic [REC_W-1:0] REC_WARN = REC_W'(WARN_LIM);
  localparam logic [REC_W-1:0] REC_PASS = REC_W'(PASS_LIM);

  always_comb begin
    conf_o.boff = (tec_i >= TEC_BOFF);
    conf_o.pass = (tec_i >= TEC_PASS) || (rec_i >= REC_PASS);
    conf_o.warn = (tec_i >= TEC_WARN) || (rec_i >= REC_WARN);
    conf_o.act  = !conf_o.pass && !conf_o.boff;
  end

  // thresholds must stay ordered: bus-off implies passive implies warning
  always_comb begin
    if (conf_o.boff) assert_boff_implies_pass_R9: assert (conf_o.pass);
    if (conf_o.pass) assert_pass_implies_warn_R10: assert (conf_o.warn);
  end
endmodule

// File: rtl/can_sticky_bank.sv
module can_sticky_bank #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) q_o[i] <= 1'b0;
      else        q_o[i] <= set_i[i] | (q_o[i] & ~clr_i);
    end

    assert_set_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> q_o[i]);
    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i[i]) |=> !q_o[i]);
    assert_keep_unread_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o[i] && !clr_i) |=> q_o[i]);
  end
endmodule

// File: rtl/can_mbx_merge.sv
module can_mbx_merge #(
  parameter int MBX_N = 16
) (
  input  logic [MBX_N-1:0] rdy_i,
  input  logic [MBX_N-1:0] abt_i,
  output logic [MBX_N-1:0] evt_o
);
  for (genvar m = 0; m < MBX_N; m++) begin : g_mbx
    assign evt_o[m] = rdy_i[m] | abt_i[m];
  end
endmodule

// File: rtl/can_status_reg.sv
module can_status_reg
  import can_stat_pkg::*;
#(
  parameter int TEC_W    = 9,
  parameter int REC_W    = 8,
  parameter int MBX_N    = 16,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128,
  parameter int BOFF_LIM = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_i,
  input  logic              tx_busy_i,
  input  logic              tx_ovl_i,
  input  logic              rx_busy_i,
  input  logic              err_bit_i,
  input  logic              err_form_i,
  input  logic              err_ack_i,
  input  logic              err_stuff_i,
  input  logic              err_crc_i,
  input  logic              tstamp_i,
  input  logic              tmr_wrap_i,
  input  logic              low_power_i,
  input  logic [TEC_W-1:0]  tec_i,
  input  logic [REC_W-1:0]  rec_i,
  input  logic [MBX_N-1:0]  mbx_rdy_i,
  input  logic [MBX_N-1:0]  mbx_abt_i,
  output logic              rd_valid_o,
  output logic [STAT_W-1:0] rd_data_o
);
  conf_t               conf;
  logic [STICKY_N-1:0] set_vec;
  logic [STICKY_N-1:0] flags;
  logic [MBX_N-1:0]    mbx_evt;
  logic [STAT_W-1:0]   word;

  can_conf_state #(
    .TEC_W(TEC_W), .REC_W(REC_W),
    .WARN_LIM(WARN_LIM), .PASS_LIM(PASS_LIM), .BOFF_LIM(BOFF_LIM)
  ) u_conf (
    .tec_i (tec_i),
    .rec_i (rec_i),
    .conf_o(conf)
  );

  always_comb begin
    set_vec = {err_bit_i, err_form_i, err_ack_i, err_stuff_i, err_crc_i,
               tstamp_i, tmr_wrap_i,
               conf.boff, conf.pass, conf.warn, conf.act};
  end

  can_sticky_bank #(.N(STICKY_N)) u_sticky (
    .clk  (clk),
    .rst_n(rst_n),
    .clr_i(rd_en_i),
    .set_i(set_vec),
    .q_o  (flags)
  );

  can_mbx_merge #(.MBX_N(MBX_N)) u_mbx (
    .rdy_i(mbx_rdy_i),
    .abt_i(mbx_abt_i),
    .evt_o(mbx_evt)
  );

  always_comb begin
    word = {tx_ovl_i, tx_busy_i, rx_busy_i,
            flags[STICKY_N-1:S_TSTP + 1],
            flags[S_TSTP], flags[S_WRAP],
            !low_power_i, low_power_i,
            flags[S_BOFF], flags[S_PASS], flags[S_WARN], flags[S_ACT],
            mbx_evt};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= word;
    end
  end

  assert_valid_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o);
  assert_no_valid_unasked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> !rd_valid_o);
  assert_busy_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> (rd_data_o[30] == $past(tx_busy_i)));
  assert_sleep_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> (rd_data_o[21] != rd_data_o[20]));
endmodule

// File: tb/can_status_reg_test.sv
module can_status_reg_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0, rd_en = 1'b0;
  logic        tx_busy = 0, tx_ovl = 0, rx_busy = 0;
  logic        e_bit = 0, e_form = 0, e_ack = 0, e_stuff = 0, e_crc = 0;
  logic        tstamp = 0, wrap = 0, lowp = 0;
  logic [8:0]  tec = '0;
  logic [7:0]  rec = '0;
  logic [15:0] mrdy = '0, mabt = '0;
  logic        rd_valid;
  logic [31:0] rd_data;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [31:0] IDLE = 32'h0021_0000;

  can_status_reg uut (
    .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en),
    .tx_busy_i(tx_busy), .tx_ovl_i(tx_ovl), .rx_busy_i(rx_busy),
    .err_bit_i(e_bit), .err_form_i(e_form), .err_ack_i(e_ack),
    .err_stuff_i(e_stuff), .err_crc_i(e_crc),
    .tstamp_i(tstamp), .tmr_wrap_i(wrap), .low_power_i(lowp),
    .tec_i(tec), .rec_i(rec), .mbx_rdy_i(mrdy), .mbx_abt_i(mabt),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: called at a falling edge, issues one read and queues its expected word
  task automatic rd(input logic [31:0] exp, input string req);
    rd_en = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops one expected word per valid beat
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk(1, 0, "R2 unexpected valid");
      else chk(rd_data, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    fork
      begin
        step(2);
        chk({31'd0, rd_valid}, 32'd0, "R1 valid in reset");
        chk(rd_data, 32'd0, "R1 data in reset");
        rst_n = 1'b1;
        step(2);
        rd(IDLE, "R12 R8 idle word");
        step(1);
        chk({31'd0, rd_valid}, 32'd0, "R2 valid drops");

        tx_busy = 1; tx_ovl = 1; rx_busy = 1;
        rd(32'hE021_0000, "R3 busy first read");
        rd(32'hE021_0000, "R3 busy after read");
        tx_busy = 0; tx_ovl = 0; rx_busy = 0;
        rd(IDLE, "R3 busy cleared");

        e_bit = 1; e_crc = 1; step(1); e_bit = 0; e_crc = 0;
        e_ack = 1; e_stuff = 1; step(1); e_ack = 0; e_stuff = 0;
        rd(32'h1721_0000, "R4 error flags");
        rd(IDLE, "R5 cleared by read");

        e_form = 1; rd(IDLE, "R6 same-cycle not seen"); e_form = 0;
        rd(32'h0821_0000, "R6 kept for next read");
        rd(IDLE, "R5 form cleared");

        tstamp = 1; wrap = 1; step(1); tstamp = 0; wrap = 0;
        rd(32'h00E1_0000, "R7 tstamp and wrap");
        rd(IDLE, "R7 cleared");

        lowp = 1; rd(32'h0011_0000, "R8 sleep"); lowp = 0;
        rd(IDLE, "R8 wake");

        rec = 8'd100; step(1);
        rd(32'h0023_0000, "R11 warning from rec");
        rd(32'h0023_0000, "R11 warning re-set");
        rec = 8'd0;
        rd(32'h0023_0000, "R5 pre-clear value");
        rd(IDLE, "R11 warning gone");

        tec = 9'd127; step(1);
        rd(32'h0023_0000, "R10 127 not passive");
        tec = 9'd130; step(1);
        rd(32'h0027_0000, "R10 passive, active held");
        rd(32'h0026_0000, "R12 active cleared");
        tec = 9'd300; step(1);
        rd(32'h002E_0000, "R9 bus-off");
        tec = 9'd0;
        rd(32'h002E_0000, "R9 held at read");
        rd(IDLE, "R12 active again");

        rec = 8'd128; step(1);
        rd(32'h0027_0000, "R10 passive from rec");
        rec = 8'd0;
        rd(32'h0026_0000, "R10 rec passive held");
        rd(IDLE, "R10 cleared");

        mrdy = 16'h0021; mabt = 16'h8001;
        rd(32'h0021_8021, "R13 mailbox or");
        mrdy = 16'h0; mabt = 16'h0;
        rd(IDLE, "R13 mailbox live");
        step(3);
        chk(exp_q.size(), 0, "R2 all reads answered");
      end
      begin
        step(5000);
        chk(1, 0, "watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule